// File: doc/BRIEF.md
# Extended Page Override Sequencer

This block opens a short, instruction-counted window during which memory addressing and register-space selection are redirected. A start strobe captures a 10-bit page number and a 2-bit length code. For the next one to four retired instructions, long and indirect addresses take their upper ten bits from the captured page rather than from one of four page registers. Register and bit accesses are steered to the extended special-function-register range. Interrupts of every kind, and class A traps, are held off.

Outside the window, the block behaves as an ordinary page translator. The two top bits of the 16-bit logical address pick one of four page registers, and that register supplies bits 23:14 of the 24-bit physical address. A class B trap condition closes an open window in the cycle it is raised.

Top module: `page_window_top`

## Requirements
- R1: After reset the window is closed: `active`, `sfrExt` and `irqLock` are 0, and `physAddr` is translated through the page registers.
- R2: A start with length code L (2 bits) opens the window from the cycle after the start edge. The window stays open for exactly L+1 later retire strobes, so code 0 gives 1 and code 3 gives 4. Cycles without a retire leave the count unchanged.
- R3: A retire strobe in the same cycle as the start strobe does not consume any of the window's count.
- R4: While the window is open and `longInd` is 1, `physAddr[23:14]` equals the captured page.
- R5: While the window is open and `longInd` is 0, `physAddr[23:14]` comes from the page register selected by `logAddr[15:14]`.
- R6: `physAddr[13:0]` always equals `logAddr[13:0]`.
- R7: While the window is closed, `logAddr[15:14]` = k selects page register k, which is `dppPages[10*k+9 : 10*k]`, as `physAddr[23:14]`.
- R8: `sfrExt` and `irqLock` are 1 exactly when `active` is 1.
- R9: While `trapB` is 1, `active`, `sfrExt` and `irqLock` are 0 in that same cycle, and the window stays closed after the edge.
- R10: A start while the window is open reloads both the page and the count from the new operands.
- R11: When `trapB` and `startStb` are both 1 in the same cycle, the trap wins and no window is opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Starts or restarts a window |
| pageOp | input | 10 | Page number captured at start |
| lenOp | input | 2 | Length code, window length = code+1 |
| retireStb | input | 1 | One instruction retired |
| trapB | input | 1 | Class B trap condition |
| logAddr | input | 16 | Logical address |
| longInd | input | 1 | Address comes from long or indirect mode |
| dppPages | input | 40 | Four 10-bit page registers; register k is bits 10k+9:10k |
| physAddr | output | 24 | Translated physical address |
| sfrExt | output | 1 | Selects the extended register range |
| irqLock | output | 1 | Holds off interrupts and class A traps |
| active | output | 1 | Window open |

## Verification
The window state changes at the clock edge that samples a start or a retire, so `active`, `sfrExt` and `irqLock` are due one cycle after that stimulus. `physAddr` is combinational from the current address inputs and that state. A class B trap is the exception: it takes effect in the same cycle, before any edge. The driver changes inputs at the falling edge and queues the result expected after the next rising edge, and the monitor compares 2 ns after that rising edge while the inputs are still held. The same-cycle trap effect is checked directly 1 ns after the trap is driven, before the edge.

// File: rtl/page_window_pkg.sv
package page_window_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadEn;  // capture new page operand
    logic decEn;   // one retire consumed
    logic clrEn;   // trap abort
  } winCtl_t;
endpackage

// File: rtl/page_window_ctrl.sv
module page_window_ctrl
  import page_window_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [LEN_W-1:0] lenOp,
  input  logic             retireStb,
  input  logic             trapB,
  output winCtl_t          ctl,
  output logic             winOn
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             countNz;

  assign countNz = (cnt != '0);

  always_comb begin
    ctl.clrEn  = trapB;
    ctl.loadEn = startStb & ~trapB;
    ctl.decEn  = retireStb & countNz & ~startStb & ~trapB;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.clrEn)  cnt <= '0;
    else if (ctl.loadEn) cnt <= {1'b0, lenOp} + CNT_W'(1);
    else if (ctl.decEn)  cnt <= cnt - CNT_W'(1);
  end

  // A trap closes the window in the same cycle
  assign winOn = countNz & ~trapB;

  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    startStb && !trapB |=> cnt == {1'b0, $past(lenOp)} + CNT_W'(1));
  p_start_no_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    startStb && retireStb && !trapB |=> cnt != '0);
  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    retireStb && countNz && !startStb && !trapB |=> cnt == $past(cnt) - CNT_W'(1));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !startStb && !retireStb && !trapB |=> $stable(cnt));
  p_trap_close_r9: assert property (@(posedge clk) disable iff (!rstN)
    trapB |=> cnt == '0);
endmodule

// File: rtl/page_window_dp.sv
module page_window_dp
  import page_window_pkg::*;
#(
  parameter int PAGE_W  = 10,
  parameter int OFS_W   = 14,
  parameter int NUM_DPP = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  winCtl_t                   ctl,
  input  logic                      winOn,
  input  logic [PAGE_W-1:0]         pageOp,
  input  logic [OFS_W+$clog2(NUM_DPP)-1:0] logAddr,
  input  logic                      longInd,
  input  logic [NUM_DPP*PAGE_W-1:0] dppPages,
  output logic [PAGE_W+OFS_W-1:0]   physAddr,
  output logic                      sfrExt,
  output logic                      irqLock
);
  localparam int SEL_W = $clog2(NUM_DPP);
  localparam int LOG_W = OFS_W + SEL_W;

  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_W-1:0] dppArr [NUM_DPP];
  logic [SEL_W-1:0]  dppSel;
  logic [PAGE_W-1:0] pageOut;

  for (genvar k = 0; k < NUM_DPP; k++) begin : g_unpack
    assign dppArr[k] = dppPages[k*PAGE_W +: PAGE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           pageReg <= '0;
    else if (ctl.loadEn) pageReg <= pageOp;
  end

  assign dppSel  = logAddr[LOG_W-1 -: SEL_W];
  assign pageOut = (winOn && longInd) ? pageReg : dppArr[dppSel];

  assign physAddr = {pageOut, logAddr[OFS_W-1:0]};
  assign sfrExt   = winOn;
  assign irqLock  = winOn;

  p_page_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadEn |=> pageReg == $past(pageOp));
  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadEn |=> $stable(pageReg));
endmodule

// File: rtl/page_window_top.sv
module page_window_top
  import page_window_pkg::*;
#(
  parameter int PAGE_W  = 10,
  parameter int OFS_W   = 14,
  parameter int NUM_DPP = 4,
  parameter int LEN_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startStb,
  input  logic [PAGE_W-1:0]         pageOp,
  input  logic [LEN_W-1:0]          lenOp,
  input  logic                      retireStb,
  input  logic                      trapB,
  input  logic [OFS_W+$clog2(NUM_DPP)-1:0] logAddr,
  input  logic                      longInd,
  input  logic [NUM_DPP*PAGE_W-1:0] dppPages,
  output logic [PAGE_W+OFS_W-1:0]   physAddr,
  output logic                      sfrExt,
  output logic                      irqLock,
  output logic                      active
);
  winCtl_t ctl;
  logic    winOn;

  page_window_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .lenOp(lenOp),
    .retireStb(retireStb), .trapB(trapB), .ctl(ctl), .winOn(winOn)
  );

  page_window_dp #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .NUM_DPP(NUM_DPP)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .winOn(winOn), .pageOp(pageOp),
    .logAddr(logAddr), .longInd(longInd), .dppPages(dppPages),
    .physAddr(physAddr), .sfrExt(sfrExt), .irqLock(irqLock)
  );

  assign active = winOn;
endmodule

// File: tb/page_window_tb.sv
module page_window_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        startStb, retireStb, trapB, longInd;
  logic [9:0]  pageOp;
  logic [1:0]  lenOp;
  logic [15:0] logAddr;
  logic [39:0] dppPages;
  logic [23:0] physAddr;
  logic        sfrExt, irqLock, active;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic        act;
    logic [23:0] addr;
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  // bench model
  int         mCount = 0;
  logic [9:0] mPage  = '0;

  always #5 clk = ~clk;

  page_window_top dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .pageOp(pageOp), .lenOp(lenOp),
    .retireStb(retireStb), .trapB(trapB), .logAddr(logAddr), .longInd(longInd),
    .dppPages(dppPages), .physAddr(physAddr), .sfrExt(sfrExt), .irqLock(irqLock),
    .active(active)
  );

  function automatic logic [9:0] dppOf(logic [1:0] k);
    return dppPages[k*10 +: 10];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: drive at falling edge, queue result due after next rising edge
  task automatic step(logic st, logic [9:0] pg, logic [1:0] ln, logic rt, logic tb,
                      logic [15:0] la, logic li, string req);
    expItem_t it;
    logic act;
    @(negedge clk);
    startStb = st; pageOp = pg; lenOp = ln; retireStb = rt; trapB = tb;
    logAddr = la; longInd = li;
    if (tb) mCount = 0;
    else if (st) begin mCount = int'(ln) + 1; mPage = pg; end
    else if (rt && mCount != 0) mCount--;
    act = (mCount != 0) && !tb;
    it.act  = act;
    it.addr = {(act && li) ? mPage : dppOf(la[15:14]), la[13:0]};
    it.req  = req;
    expQ.push_back(it);
    if (tb) begin  // R9: same-cycle close, before the edge
      #1;
      check("R9", {31'd0, active}, 32'd0, "active during trap");
      check("R9", {31'd0, irqLock}, 32'd0, "irqLock during trap");
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.req, {31'd0, active}, {31'd0, e.act}, "active");
        check("R8", {30'd0, sfrExt, irqLock}, {30'd0, e.act, e.act}, "sfrExt/irqLock");
        check(e.req, {8'd0, physAddr}, {8'd0, e.addr}, "physAddr");
        check("R6", {18'd0, physAddr[13:0]}, {18'd0, logAddr[13:0]}, "offset");
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    dppPages = {10'h3C1, 10'h255, 10'h0F0, 10'h18A};
    rstN = 1'b0; startStb = 0; retireStb = 0; trapB = 0; longInd = 1;
    pageOp = '0; lenOp = '0; logAddr = 16'h8123;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1", {31'd0, active}, 32'd0, "active after reset");
    check("R1", {8'd0, physAddr}, {8'd0, dppOf(2'd2), 14'h0123}, "addr after reset");
    // R7: each page register when closed
    for (int k = 0; k < 4; k++)
      step(0, '0, '0, 1, 0, {k[1:0], 14'h1A5 + 14'(k)}, 1, "R7");
    // R2/R3: length 3, retire on start cycle ignored
    step(1, 10'h2A5, 2'd2, 1, 0, 16'h4321, 1, "R3");
    step(0, '0, '0, 0, 0, 16'hC777, 1, "R4");
    step(0, '0, '0, 1, 0, 16'h0ABC, 0, "R5");
    step(0, '0, '0, 0, 0, 16'h8001, 0, "R5");
    step(0, '0, '0, 1, 0, 16'h3FFF, 1, "R4");
    step(0, '0, '0, 1, 0, 16'h5555, 1, "R2");
    step(0, '0, '0, 1, 0, 16'hFFFF, 1, "R7");
    // R2: shortest window
    step(1, 10'h011, 2'd0, 0, 0, 16'h0000, 1, "R2");
    step(0, '0, '0, 1, 0, 16'h4444, 1, "R2");
    // R2: longest window
    step(1, 10'h3FF, 2'd3, 0, 0, 16'h1234, 1, "R2");
    for (int i = 0; i < 4; i++) step(0, '0, '0, 1, 0, 16'h2222 * 16'(i+1), 1, "R2");
    // R10: restart inside window
    step(1, 10'h155, 2'd1, 0, 0, 16'h6000, 1, "R10");
    step(0, '0, '0, 1, 0, 16'h6001, 1, "R10");
    step(1, 10'h0AA, 2'd0, 1, 0, 16'h7002, 1, "R10");
    step(0, '0, '0, 0, 0, 16'hB003, 1, "R10");
    step(0, '0, '0, 1, 0, 16'hB004, 1, "R10");
    // R9: trap mid-window
    step(1, 10'h2C3, 2'd3, 0, 0, 16'h9999, 1, "R4");
    step(0, '0, '0, 0, 1, 16'h9999, 1, "R9");
    step(0, '0, '0, 0, 0, 16'h9999, 1, "R9");
    // R11: trap and start together
    step(1, 10'h1E1, 2'd3, 0, 1, 16'hD00D, 1, "R11");
    step(0, '0, '0, 0, 0, 16'hD00D, 1, "R11");
    @(negedge clk);
    startStb = 0; retireStb = 0; trapB = 0;
    repeat (3) @(posedge clk);
    #3;
    finish();
  end
endmodule